// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block decides where a three-stage (fetch, decode, execute) 32-bit core fetches next. It holds the fetch program counter. Each cycle it looks at the control-flow instruction that sits in the execute stage: its opcode, the address of that instruction, two register operands and the low 26 bits of the instruction word. Four conditional branches compare the two register operands. One unconditional jump builds an absolute target as four times a 26-bit word index.

When the instruction in execute redirects control, `taken` rises and `next_pc` carries the target in the same cycle. The fetch counter loads the target on the next edge. On that edge two wrong-path instructions move into decode and execute, so the unit raises `flush` for exactly that one following cycle. The surrounding pipeline uses `flush` to invalidate those two instructions. The unit also ignores the instruction in execute while `flush` is high.

In every other cycle the fetch counter steps by one 32-bit word. All pins are plain control and data pins with no handshake. The fetch counter advances on every edge that is not a reset edge.

Top module: `npc_unit`

## Requirements
- R1: On the first cycle after a synchronous reset, `pc` is 0 and `flush` is low.
- R2: In a cycle where `taken` is low, `next_pc` equals `pc + 4`, and `pc` holds that value after the next edge.
- R3: Only opcodes 0x20 (branch if equal), 0x21 (branch if unequal), 0x22 (branch if less), 0x23 (branch if greater) and 0x24 (jump) can raise `taken`. Every other 6-bit opcode leaves `taken` low.
- R4: Branch if equal is taken exactly when `opnd_a == opnd_b`. Branch if unequal is taken exactly when the two operands differ.
- R5: Branch if less is taken exactly when `opnd_a < opnd_b`, and branch if greater exactly when `opnd_a > opnd_b`. Both compare the operands as signed two's-complement values.
- R6: A taken conditional branch sets `next_pc = ex_pc + 4 + 4*S`. S is `ex_field[15:0]` sign-extended to 32 bits, so negative offsets branch backward.
- R7: The jump (opcode 0x24) is always taken. It sets `next_pc = 4*ex_field`, zero-extended, regardless of `ex_pc`.
- R8: `flush` is high in exactly the one cycle that follows a cycle with `taken` high.
- R9: While `flush` is high, the instruction presented in execute is ignored: `taken` stays low and `next_pc` is `pc + 4`.
- R10: While `ex_valid` is low, `taken` stays low whatever the opcode and operands are.
- R11: After a cycle with `taken` high, `pc` equals the `next_pc` value shown in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ex_valid | input | 1 | The execute stage holds a real instruction |
| ex_opcode | input | 6 | Opcode of the instruction in execute |
| ex_pc | input | 32 | Address of the instruction in execute |
| opnd_a | input | 32 | First register operand |
| opnd_b | input | 32 | Second register operand |
| ex_field | input | 26 | Low 26 bits of the instruction word (jump index; bits 15:0 are the branch offset) |
| pc | output | 32 | Fetch program counter |
| next_pc | output | 32 | Address loaded into `pc` at the next edge |
| taken | output | 1 | The instruction in execute redirects control |
| flush | output | 1 | Invalidate the instructions now in decode and execute |

## Verification
`taken` and `next_pc` are combinational, so they are due in the same cycle the execute inputs are applied. `pc` and `flush` are registered and follow one edge later. The bench drives its inputs just after each falling edge and compares all four outputs with a behavioural model 1 ns later. It advances the model's counter and flush state at the rising edge that the design itself uses. This means a redirect is checked first on `next_pc` in its own cycle, then on `pc` and `flush` in the next cycle. A branch placed in the cycle right after a redirect is checked as ignored.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam int OPC_W      = 6;
  localparam int INSN_BYTES = 4;

  typedef enum logic [2:0] {
    CF_NONE,
    CF_EQ,
    CF_NE,
    CF_LT,
    CF_GT,
    CF_JMP
  } cf_kind_e;

  // Opcode values; their order fixes which comparison each one picks.
  localparam logic [OPC_W-1:0] OPC_EQ  = 6'b100000;
  localparam logic [OPC_W-1:0] OPC_NE  = 6'b100001;
  localparam logic [OPC_W-1:0] OPC_LT  = 6'b100010;
  localparam logic [OPC_W-1:0] OPC_GT  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_JMP = 6'b100100;

  function automatic cf_kind_e cf_decode(input logic [OPC_W-1:0] opc);
    cf_kind_e k;
    case (opc)
      OPC_EQ:  k = CF_EQ;
      OPC_NE:  k = CF_NE;
      OPC_LT:  k = CF_LT;
      OPC_GT:  k = CF_GT;
      OPC_JMP: k = CF_JMP;
      default: k = CF_NONE;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/npc_cond.sv
module npc_cond #(
  parameter int XLEN       = 32,
  parameter bit SIGNED_CMP = 1'b1
) (
  input  npc_pkg::cf_kind_e kind,
  input  logic [XLEN-1:0]   a,
  input  logic [XLEN-1:0]   b,
  output logic              hit
);
  import npc_pkg::*;

  logic eq, lt, gt;

  assign eq = (a == b);

  // The parameter picks how "less" and "greater" read the operands.
  generate
    if (SIGNED_CMP) begin : g_signed
      assign lt = $signed(a) < $signed(b);
      assign gt = $signed(a) > $signed(b);
    end else begin : g_unsigned
      assign lt = a < b;
      assign gt = a > b;
    end
  endgenerate

  always_comb begin
    case (kind)
      CF_EQ:   hit = eq;
      CF_NE:   hit = !eq;
      CF_LT:   hit = lt;
      CF_GT:   hit = gt;
      CF_JMP:  hit = 1'b1;
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/npc_target.sv
module npc_target #(
  parameter int XLEN  = 32,
  parameter int IDX_W = 26,
  parameter int IMM_W = 16
) (
  input  logic [XLEN-1:0]  base,
  input  logic [IDX_W-1:0] field,
  input  logic             is_jump,
  output logic [XLEN-1:0]  target
);
  import npc_pkg::*;

  localparam int SH = $clog2(INSN_BYTES);

  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] br_off;
  logic [XLEN-1:0] fall_thru;
  logic [XLEN-1:0] br_tgt;
  logic [XLEN-1:0] jmp_tgt;

  assign imm_ext   = {{(XLEN-IMM_W){field[IMM_W-1]}}, field[IMM_W-1:0]};
  assign br_off    = imm_ext << SH;
  assign fall_thru = base + XLEN'(INSN_BYTES);
  assign br_tgt    = fall_thru + br_off;
  assign jmp_tgt   = {{(XLEN-IDX_W-SH){1'b0}}, field, {SH{1'b0}}};
  assign target    = is_jump ? jmp_tgt : br_tgt;

endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter int XLEN       = 32,
  parameter int IDX_W      = 26,
  parameter int IMM_W      = 16,
  parameter bit SIGNED_CMP = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ex_valid,
  input  logic [npc_pkg::OPC_W-1:0] ex_opcode,
  input  logic [XLEN-1:0]           ex_pc,
  input  logic [XLEN-1:0]           opnd_a,
  input  logic [XLEN-1:0]           opnd_b,
  input  logic [IDX_W-1:0]          ex_field,
  output logic [XLEN-1:0]           pc,
  output logic [XLEN-1:0]           next_pc,
  output logic                      taken,
  output logic                      flush
);
  import npc_pkg::*;

  cf_kind_e        kind;
  logic            hit;
  logic            live;
  logic [XLEN-1:0] target;
  logic [XLEN-1:0] pc_q;
  logic            flush_q;

  assign kind = cf_decode(ex_opcode);

  npc_cond #(.XLEN(XLEN), .SIGNED_CMP(SIGNED_CMP)) i_cond (
    .kind (kind),
    .a    (opnd_a),
    .b    (opnd_b),
    .hit  (hit)
  );

  npc_target #(.XLEN(XLEN), .IDX_W(IDX_W), .IMM_W(IMM_W)) i_target (
    .base    (ex_pc),
    .field   (ex_field),
    .is_jump (kind == CF_JMP),
    .target  (target)
  );

  // An instruction in the shadow of a redirect is wrong-path.
  assign live    = ex_valid && !flush_q;
  assign taken   = live && hit;
  assign next_pc = taken ? target : pc_q + XLEN'(INSN_BYTES);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      flush_q <= 1'b0;
    end else begin
      pc_q    <= next_pc;
      flush_q <= taken;
    end
  end

  assign pc    = pc_q;
  assign flush = flush_q;

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            ex_valid,
  input logic [5:0]      ex_opcode,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] next_pc,
  input logic            taken,
  input logic            flush
);
  logic past_valid = 1'b0;
  always_ff @(posedge clk) past_valid <= 1'b1;

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    (past_valid && $past(rst)) |-> (pc == '0 && !flush));

  p_step_word_r2: assert property (@(posedge clk) disable iff (rst)
    !taken |=> (pc == $past(pc) + XLEN'(4)));

  p_nonctrl_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (ex_opcode[5:3] != 3'b100 || ex_opcode[2:0] > 3'd4) |-> !taken);

  p_jump_always_r7: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && !flush && ex_opcode == 6'h24) |-> taken);

  p_flush_follows_r8: assert property (@(posedge clk) disable iff (rst)
    taken |=> flush);

  p_flush_single_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> !flush);

  p_shadow_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    flush |-> !taken);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !ex_valid |-> !taken);

  p_redirect_load_r11: assert property (@(posedge clk) disable iff (rst)
    taken |=> (pc == $past(next_pc)));

endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN)) i_npc_unit_chk (
  .clk       (clk),
  .rst       (rst),
  .ex_valid  (ex_valid),
  .ex_opcode (ex_opcode),
  .pc        (pc),
  .next_pc   (next_pc),
  .taken     (taken),
  .flush     (flush)
);

// File: tb/test_npc_unit.sv
`timescale 1ns/1ps
module test_npc_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ex_valid = 1'b0;
  logic [5:0]  ex_opcode = '0;
  logic [31:0] ex_pc = '0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [25:0] ex_field = '0;
  logic [31:0] pc, next_pc;
  logic        taken, flush;

  int checks = 0;
  int errors = 0;

  // Behavioural model state
  longint m_pc = 0;
  bit     m_flush = 1'b0;
  bit     m_prev_taken = 1'b0;

  always #2.5 clk = ~clk;

  npc_unit i_npc_unit (
    .clk(clk), .rst(rst), .ex_valid(ex_valid), .ex_opcode(ex_opcode),
    .ex_pc(ex_pc), .opnd_a(opnd_a), .opnd_b(opnd_b), .ex_field(ex_field),
    .pc(pc), .next_pc(next_pc), .taken(taken), .flush(flush)
  );

  task automatic chk(input string tg, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tg, act, exp);
    end
  endtask

  function automatic bit ref_taken(input bit v, input int opc, input longint a, input longint b);
    bit t;
    if (!v || m_flush) return 1'b0;
    case (opc)
      32: t = (a == b);
      33: t = (a != b);
      34: t = (a < b);
      35: t = (a > b);
      36: t = 1'b1;
      default: t = 1'b0;
    endcase
    return t;
  endfunction

  task automatic step(input bit v, input logic [5:0] opc, input logic [31:0] a,
                      input logic [31:0] b, input logic [31:0] epc,
                      input logic [25:0] fld, input string tg);
    bit     et;
    longint en;
    longint off;
    @(negedge clk);
    ex_valid = v; ex_opcode = opc; opnd_a = a; opnd_b = b; ex_pc = epc; ex_field = fld;
    #1;
    chk(m_prev_taken ? "R11 pc" : "R2 pc", pc, 32'(m_pc));
    chk("R8 flush", {31'd0, flush}, {31'd0, m_flush});
    et = ref_taken(v, int'(opc), longint'($signed(a)), longint'($signed(b)));
    if (!et) begin
      en = (m_pc + 4) % 64'h1_0000_0000;
    end else if (opc == 6'h24) begin
      en = longint'(fld) * 4;
    end else begin
      off = longint'($signed(fld[15:0]));
      en = (longint'(epc) + 4 + off * 4) & 64'hFFFF_FFFF;
    end
    chk({tg, " taken"}, {31'd0, taken}, {31'd0, et});
    chk({tg, " next_pc"}, next_pc, 32'(en));
    @(posedge clk);
    m_pc = en;
    m_flush = et;
    m_prev_taken = et;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ex_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 pc", pc, 32'd0);
    chk("R1 flush", {31'd0, flush}, 32'd0);
    @(posedge clk);
    m_pc = 4; m_flush = 1'b0; m_prev_taken = 1'b0;
  endtask

  initial begin
    do_reset();
    // R10 / R2: idle and sequential flow
    step(1'b0, 6'h20, 32'd5, 32'd5, 32'h100, 26'd8, "R10");
    step(1'b0, 6'h24, 32'd0, 32'd1, 32'h100, 26'd9, "R10");
    step(1'b1, 6'h00, 32'd1, 32'd2, 32'h100, 26'd3, "R2");
    // R3: non-control opcodes with equal operands
    step(1'b1, 6'h00, 32'd7, 32'd7, 32'h40, 26'd2, "R3");
    step(1'b1, 6'h1F, 32'd7, 32'd7, 32'h40, 26'd2, "R3");
    step(1'b1, 6'h25, 32'd7, 32'd7, 32'h40, 26'd2, "R3");
    step(1'b1, 6'h3F, 32'd7, 32'd7, 32'h40, 26'd2, "R3");
    // R4: equal / unequal
    step(1'b1, 6'h20, 32'hDEAD, 32'hDEAD, 32'h200, 26'd3, "R4");
    // R9: branch in the redirect shadow is ignored
    step(1'b1, 6'h24, 32'd0, 32'd0, 32'h0, 26'h123, "R9");
    step(1'b1, 6'h20, 32'd1, 32'd2, 32'h200, 26'd3, "R4");
    step(1'b1, 6'h21, 32'd1, 32'd2, 32'h300, 26'd1, "R4");
    step(1'b0, 6'h00, 32'd0, 32'd0, 32'h0, 26'd0, "R8");
    step(1'b1, 6'h21, 32'h55, 32'h55, 32'h300, 26'd1, "R4");
    // R5: signed compares
    step(1'b1, 6'h22, 32'hFFFF_FFFF, 32'd1, 32'h1000, 26'd4, "R5");
    step(1'b0, 6'h00, 32'd0, 32'd0, 32'h0, 26'd0, "R8");
    step(1'b1, 6'h23, 32'hFFFF_FFFF, 32'd1, 32'h1000, 26'd4, "R5");
    step(1'b1, 6'h23, 32'h7FFF_FFFF, 32'h8000_0000, 32'h1000, 26'd4, "R5");
    step(1'b0, 6'h00, 32'd0, 32'd0, 32'h0, 26'd0, "R8");
    step(1'b1, 6'h22, 32'd3, 32'd3, 32'h1000, 26'd4, "R5");
    // R6: backward branch and extreme offsets
    step(1'b1, 6'h20, 32'd0, 32'd0, 32'h2000, 26'h0_FFFE, "R6");
    step(1'b0, 6'h00, 32'd0, 32'd0, 32'h0, 26'd0, "R8");
    step(1'b1, 6'h21, 32'd0, 32'd9, 32'h2000, 26'h3F_8000, "R6");
    step(1'b0, 6'h00, 32'd0, 32'd0, 32'h0, 26'd0, "R8");
    step(1'b1, 6'h20, 32'd4, 32'd4, 32'h2000, 26'h0_7FFF, "R6");
    step(1'b0, 6'h00, 32'd0, 32'd0, 32'h0, 26'd0, "R8");
    // R7: jumps, largest index and index zero
    step(1'b1, 6'h24, 32'd1, 32'd2, 32'hFFFF_0000, 26'h3FF_FFFF, "R7");
    step(1'b0, 6'h00, 32'd0, 32'd0, 32'h0, 26'd0, "R8");
    step(1'b1, 6'h24, 32'd1, 32'd2, 32'h500, 26'd0, "R7");
    step(1'b0, 6'h00, 32'd0, 32'd0, 32'h0, 26'd0, "R11");
    // R1: reset in the middle of a run
    do_reset();
    step(1'b0, 6'h00, 32'd0, 32'd0, 32'h0, 26'd0, "R2");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule